// File: doc/BRIEF.md
# DRAM Row/Column Sequencer with Refresh

This controller sits between a simple processor memory request and a DRAM array whose address pins carry the row and the column at different times. The processor raises a request, qualified by a memory/IO select, and holds it until the controller returns a one-cycle ready. Each access is a fixed chain of clocked states. The row half of the address goes out first and is latched by a falling row strobe. The column half then replaces it on the same pins and is latched by a falling column strobe. Write enable or output enable follows, and the read nibble is captured for the processor.

Stored charge leaks away, so a free-running interval timer raises a refresh request. Refresh cycles use only the row strobe. They take their row from an internal counter that steps by one after each refresh. A refresh starts only between processor accesses and wins over a request that arrives at the same moment. A request made while refresh is pending or running is held off and completed afterwards.

The defaults give a 4M x 4 array: 2048 rows by 2048 columns, 11 multiplexed address pins and a 4-bit data nibble.

Top module: `dram_ctrl`

## Requirements
- R1: For an access, the row strobe falls with dram_addr equal to addr[21:11]. The column strobe falls at least one cycle later, with dram_addr equal to addr[10:0]. The column strobe never falls outside a processor access.
- R2: cas_n is low only while ras_n is low, and dram_addr holds still in every cycle that cas_n stays low.
- R3: A write (wr=1) drives we_n low only while cas_n is low, with dq_out equal to the request's wdata. oe_n stays high throughout.
- R4: A read (wr=0) drives oe_n low only in the cycle after cas_n fell. we_n and oe_n are never low together. rdata returns the nibble last written to that address.
- R5: A request presented to an idle controller with no refresh due produces ready exactly 6 clock edges later, for one cycle, with rdata valid in that cycle.
- R6: A request with is_mem=0 is ignored: no column strobe and no ready for as long as it is held.
- R7: A refresh cycle lowers ras_n while cas_n stays high. Its row address starts at 0 after reset and increases by one per refresh, wrapping modulo 2048.
- R8: With the bus idle, refreshes start exactly REF_PERIOD cycles apart. A refresh that is due wins over a request arriving at the same idle cycle, which then completes 11 edges after it was raised. A request raised in the first low-strobe cycle of a refresh completes 9 edges later.
- R9: During and after reset, ras_n, cas_n, we_n and oe_n are high and ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Processor access request, held until ready |
| is_mem | input | 1 | 1 selects memory space; 0 means IO, ignored |
| wr | input | 1 | 1 for write, 0 for read |
| addr | input | 22 | Nibble address: row in [21:11], column in [10:0] |
| wdata | input | 4 | Write nibble |
| ready | output | 1 | One-cycle completion pulse |
| rdata | output | 4 | Read nibble, valid with ready |
| dram_addr | output | 11 | Multiplexed row/column address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| dq_out | output | 4 | Data driven to the DRAM on writes |
| dq_in | input | 4 | Data returned from the DRAM on reads |

## Verification
The row strobe falls 2 edges after the controller accepts a request, and the column strobe falls 2 edges after that. The enable strobe follows in the same or the next cycle, and ready arrives on the 6th edge. The bench drives on falling edges and compares every strobe and address against its own model of the DRAM pins at each falling edge. It checks each latency against 6, 9 or 11 edges, depending on whether a refresh was idle, running or due when the request was raised. Refresh spacing is measured only after two undisturbed refreshes, so no gap delayed by an access is compared with REF_PERIOD.

// File: rtl/dram_ctrl.sv
module dram_ctrl #(
  parameter int ROW_W      = 11,
  parameter int COL_W      = 11,
  parameter int DQ_W       = 4,
  parameter int REF_PERIOD = 780
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req,
  input  logic                   is_mem,
  input  logic                   wr,
  input  logic [ROW_W+COL_W-1:0] addr,
  input  logic [DQ_W-1:0]        wdata,
  output logic                   ready,
  output logic [DQ_W-1:0]        rdata,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
  output logic                   ras_n,
  output logic                   cas_n,
  output logic                   we_n,
  output logic                   oe_n,
  output logic [DQ_W-1:0]        dq_out,
  input  logic [DQ_W-1:0]        dq_in
);

  localparam int AW  = ROW_W + COL_W;
  localparam int MAW = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int RCW = (REF_PERIOD > 1) ? $clog2(REF_PERIOD) : 1;

  typedef enum logic [3:0] {
    S_IDLE, S_ROW, S_RAS, S_MUX, S_CAS, S_DATA, S_END, S_PRE,
    R_ROW, R_RAS, R_HOLD, R_PRE
  } st_t;

  st_t              st;
  logic [AW-1:0]    a_q;
  logic             wr_q;
  logic [DQ_W-1:0]  wd_q;
  logic [DQ_W-1:0]  rd_q;
  logic [ROW_W-1:0] rf_row;
  logic [RCW-1:0]   ref_cnt;
  logic             ref_pend;

  wire accept   = (st == S_IDLE) && !ref_pend && req && is_mem;
  wire ref_go   = (st == S_IDLE) && ref_pend;
  wire ref_tick = (ref_cnt == RCW'(REF_PERIOD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt  <= '0;
      ref_pend <= 1'b0;
    end else begin
      ref_cnt <= ref_tick ? '0 : ref_cnt + 1'b1;
      if (ref_tick)    ref_pend <= 1'b1;
      else if (ref_go) ref_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      a_q    <= '0;
      wr_q   <= 1'b0;
      wd_q   <= '0;
      rd_q   <= '0;
      rf_row <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (ref_go) st <= R_ROW;
          else if (accept) begin
            st   <= S_ROW;
            a_q  <= addr;
            wr_q <= wr;
            wd_q <= wdata;
          end
        end
        S_ROW:  st <= S_RAS;
        S_RAS:  st <= S_MUX;
        S_MUX:  st <= S_CAS;
        S_CAS:  st <= S_DATA;
        S_DATA: begin
          st <= S_END;
          if (!wr_q) rd_q <= dq_in;
        end
        S_END:  st <= S_PRE;
        S_PRE:  st <= S_IDLE;
        R_ROW:  st <= R_RAS;
        R_RAS:  st <= R_HOLD;
        R_HOLD: st <= R_PRE;
        R_PRE: begin
          st     <= S_IDLE;
          rf_row <= rf_row + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  wire row_phase = (st == S_ROW) || (st == S_RAS);
  wire col_phase = (st == S_MUX) || (st == S_CAS) || (st == S_DATA);
  wire ref_phase = (st == R_ROW) || (st == R_RAS) || (st == R_HOLD) || (st == R_PRE);
  wire cas_on    = (st == S_CAS) || (st == S_DATA);

  always_comb begin
    if (ref_phase)      dram_addr = MAW'(rf_row);
    else if (col_phase) dram_addr = MAW'(a_q[COL_W-1:0]);
    else                dram_addr = MAW'(a_q[AW-1:COL_W]);
  end

  assign ras_n  = !((st == S_RAS) || col_phase || (st == R_RAS) || (st == R_HOLD));
  assign cas_n  = !cas_on;
  assign we_n   = !(wr_q && cas_on);
  assign oe_n   = !(!wr_q && (st == S_DATA));
  assign dq_out = wd_q;
  assign ready  = (st == S_END);
  assign rdata  = rd_q;

  wire unused_ok = row_phase;

  assert_cas_needs_ras_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && $past(!cas_n)) |-> $stable(dram_addr));

  assert_we_oe_apart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !oe_n));

  assert_oe_after_cas_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> $past(!cas_n));

  assert_ready_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);

  assert_io_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !ref_pend && req && !is_mem) |=> (ras_n && !ready));

  assert_refresh_no_cas_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !unused_ok && ref_phase) |-> cas_n);

endmodule

// File: tb/dram_ctrl_test.sv
module dram_ctrl_test;
  localparam int RP = 40;

  logic        clk = 0, rst_n = 0, req = 0, is_mem = 0, wr = 0;
  logic [21:0] addr = '0;
  logic [3:0]  wdata = '0;
  logic [3:0]  dq_in = '0;
  wire         ready, ras_n, cas_n, we_n, oe_n;
  wire  [3:0]  rdata, dq_out;
  wire  [10:0] dram_addr;

  dram_ctrl #(.REF_PERIOD(RP)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .is_mem(is_mem), .wr(wr), .addr(addr),
    .wdata(wdata), .ready(ready), .rdata(rdata), .dram_addr(dram_addr),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .dq_out(dq_out), .dq_in(dq_in));

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // DRAM model and pin-level reference, evaluated every clock
  logic [3:0]  mem [int];
  logic [10:0] lrow = '0, lcol = '0, prev_addr = '0;
  logic        prev_ras = 1, prev_cas = 1;
  bit          cyc_cas = 0, acc_on = 0, acc_wr = 0, gap_check = 0;
  logic [21:0] acc_addr = '0;
  logic [3:0]  acc_wd = '0;
  int          cyc = 0, fall_cyc = 0, last_rf = 0, rf_seen = 0, exp_rf = 0;

  always @(negedge clk) if (rst_n && !done) begin
    cyc++;
    if (prev_ras && !ras_n) begin
      lrow = dram_addr; cyc_cas = 0; fall_cyc = cyc;
    end
    if (prev_cas && !cas_n) begin
      chk(acc_on, "R1", "column strobe outside access", 0, 1);
      chk(!prev_ras, "R2", "row strobe low a cycle before column", prev_ras, 0);
      chk(lrow == acc_addr[21:11], "R1", "row address at ras fall", lrow, acc_addr[21:11]);
      chk(dram_addr == acc_addr[10:0], "R1", "column address at cas fall", dram_addr, acc_addr[10:0]);
      lcol = dram_addr; cyc_cas = 1;
    end
    if (!cas_n && !prev_cas)
      chk(dram_addr == prev_addr, "R2", "address held under cas", dram_addr, prev_addr);
    if (!cas_n)
      chk(!ras_n, "R2", "cas low without ras", ras_n, 0);
    if (!we_n) begin
      chk(acc_wr && !cas_n && oe_n, "R3", "we_n only in write under cas", {acc_wr, cas_n, oe_n}, 3'b101);
      chk(dq_out == acc_wd, "R3", "write data", dq_out, acc_wd);
      mem[int'({lrow, lcol})] = dq_out;
    end
    if (!oe_n) begin
      chk(!acc_wr && !prev_cas && we_n, "R4", "oe_n only in read after cas", {acc_wr, prev_cas, we_n}, 3'b001);
      dq_in = mem.exists(int'({lrow, lcol})) ? mem[int'({lrow, lcol})] : 4'h0;
    end
    if (!prev_ras && ras_n && !cyc_cas) begin
      chk(lrow == exp_rf[10:0], "R7", "refresh row", lrow, exp_rf);
      if (gap_check)
        chk(fall_cyc - last_rf == RP, "R8", "idle refresh spacing", fall_cyc - last_rf, RP);
      last_rf = fall_cyc;
      exp_rf  = (exp_rf + 1) % 2048;
      rf_seen++;
    end
    prev_ras = ras_n; prev_cas = cas_n; prev_addr = dram_addr;
  end

  task automatic access(input logic [21:0] a, input bit w, input logic [3:0] d,
                        output logic [3:0] q, output int lat, output int nref);
    int base = rf_seen;
    acc_on = 1; acc_addr = a; acc_wr = w; acc_wd = d;
    req = 1; is_mem = 1; wr = w; addr = a; wdata = d; lat = 0;
    do begin @(negedge clk); lat++; end while (!ready && lat < 40);
    q = rdata; nref = rf_seen - base;
    req = 0; acc_on = 0;
    @(negedge clk);
    chk(!ready, "R5", "ready lasts one cycle", ready, 0);
    @(negedge clk);
  endtask

  task automatic lat_check(input int lat, input int nref);
    if (nref == 0) chk(lat == 6, "R5", "latency idle", lat, 6);
    else chk(lat > 6 && lat <= 11, "R8", "latency with refresh", lat, 11);
  endtask

  logic [21:0] ta [6] = '{22'h000000, 22'h3FFFFF, {11'd5, 11'd7},
                          {11'd5, 11'd8}, {11'd6, 11'd7}, {11'h400, 11'h3FF}};
  logic [3:0]  td [6] = '{4'h3, 4'hC, 4'h5, 4'hA, 4'h9, 4'h6};

  initial begin
    logic [3:0] q;
    int lat, nref, base;
    repeat (3) @(negedge clk);
    chk({ras_n, cas_n, we_n, oe_n} == 4'hF, "R9", "strobes in reset", {ras_n, cas_n, we_n, oe_n}, 4'hF);
    chk(!ready, "R9", "ready in reset", ready, 0);
    rst_n = 1;
    @(negedge clk);
    chk({ras_n, cas_n, we_n, oe_n} == 4'hF && !ready, "R9", "idle after reset",
        {ras_n, cas_n, we_n, oe_n, ready}, 5'h1E);

    for (int i = 0; i < 6; i++) begin
      access(ta[i], 1, td[i], q, lat, nref);
      lat_check(lat, nref);
    end
    for (int i = 0; i < 6; i++) begin
      access(ta[i], 0, 4'h0, q, lat, nref);
      lat_check(lat, nref);
      chk(q == td[i], "R4", "read after write", q, td[i]);
    end
    access(ta[2], 1, 4'hE, q, lat, nref);
    access(ta[2], 0, 4'h0, q, lat, nref);
    chk(q == 4'hE, "R4", "overwrite read back", q, 4'hE);
    access(ta[3], 0, 4'h0, q, lat, nref);
    chk(q == 4'hA, "R4", "neighbour column untouched", q, 4'hA);

    // IO-space request must be ignored (R6)
    req = 1; is_mem = 0; wr = 1; addr = ta[0]; wdata = 4'hF;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk(!ready && cas_n, "R6", "io request ignored", {ready, cas_n}, 2'b01);
    end
    req = 0; @(negedge clk);
    access(ta[0], 0, 4'h0, q, lat, nref);
    chk(q == 4'h3, "R6", "io request left memory unchanged", q, 4'h3);

    // Idle refresh spacing (R8) and row stepping (R7)
    base = rf_seen;
    wait (rf_seen >= base + 2);
    gap_check = 1;
    base = rf_seen;
    wait (rf_seen >= base + 3);
    gap_check = 0;

    // Request raised in first low cycle of a refresh (R8)
    do @(negedge clk); while (ras_n);
    access(ta[1], 0, 4'h0, q, lat, nref);
    chk(lat == 9, "R8", "request stalled by refresh", lat, 9);
    chk(nref == 1, "R8", "refresh finished before ready", nref, 1);
    chk(q == 4'hC, "R8", "stalled read data", q, 4'hC);

    // Request colliding with a due refresh (R8)
    base = rf_seen;
    wait (rf_seen >= base + 2);
    do @(negedge clk); while (ras_n);
    repeat (RP - 2) @(negedge clk);
    access(ta[5], 0, 4'h0, q, lat, nref);
    chk(lat == 11, "R8", "refresh wins over request", lat, 11);
    chk(nref == 1, "R8", "one refresh before access", nref, 1);
    chk(q == 4'h6, "R4", "read after priority wait", q, 4'h6);
    chk(exp_rf > 3, "R7", "refresh rows advanced", exp_rf, 4);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule